// File: doc/BRIEF.md
# Linked-List Key Search Walker

This block follows a singly linked list held in memory on behalf of a host processor. The host writes a kernel selector, a head pointer, a search key and the positions of the key and link fields inside a node, then writes the go register. From then on the walker runs without the host. It reads the key field of the current node. If that key differs from the search key, it reads the node's link field, and the returned pointer becomes the base address of the next node. The walk stops at a null link or at a key match, and the block leaves a done flag, a found flag and the final node pointer on its outputs.

Each pending load waits in a small ready queue. An entry holds a load identifier (key load or link load), a base address and a field offset, and the request address is the sum of base and offset. Returned words are stored in a result buffer indexed by load identifier, and the termination logic reads them from there. A second kernel walks to the last node of the list and reads only the link fields. The memory port keeps a single request in flight. Its request channel uses a valid/ready handshake and its response channel carries a valid strobe only.

Top module: `chain_seek_engine`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `found` and `mem_req_valid` are 0 and `result_ptr` is 0.
- R2: A host write (`cfg_we`=1) takes effect at the clock edge and uses these offsets: 0 kernel selector, 1 head pointer, 2 search key, 3 key-field offset, 4 link-field offset, 7 go (acts only when `cfg_wdata[0]`=1). An accepted go with a non-null head raises `busy` and clears `done` and `found` in the following cycle, and the walk later ends with `done`=1.
- R3: With a kernel selector other than 1 (search kernel), each node produces a key load at node+key offset with tag 0, followed by a link load at node+link offset with tag 1. Addresses wrap modulo 2^AW.
- R4: When a node's key equals the search key, the walk ends with `found`=1 and `result_ptr` equal to that node's address. No load of that node's link field is issued, so a match at position m (counting from 0) takes exactly 2m+1 requests, and the last of them is the key load.
- R5: When a link load returns 0 and no node matched, the walk ends with `found`=0 and `result_ptr`=0 after exactly 2N requests for N nodes.
- R6: With kernel selector 1 (tail kernel), only link loads (tag 1) are issued, one per node. For N>0 nodes the walk ends with `found`=1 and `result_ptr` equal to the last node's address.
- R7: A go with a null head pointer finishes without any memory request, leaving `done`=1, `found`=0 and `result_ptr`=0.
- R8: At most one request is outstanding at a time. While `mem_req_valid`=1 and `mem_req_ready`=0, the request stays valid with unchanged address and tag. A response only ever arrives while a request is outstanding.
- R9: Host writes to any register, go included, are ignored while `busy`=1, and the running walk finishes with the result it would have had without them.
- R10: `done`, `found` and `result_ptr` hold their values until the next accepted go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | RAW (3) | Host register offset |
| cfg_wdata | input | AW (16) | Host write data |
| mem_req_valid | output | 1 | Load request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW (16) | Load address (base + offset) |
| mem_req_tag | output | 1 | Load identifier: 0 key, 1 link |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_data | input | AW (16) | Returned load data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk finished |
| found | output | 1 | Last walk ended at a node (match, or tail in the tail kernel) |
| result_ptr | output | AW (16) | Final node address, 0 on a miss |

## Verification
The hardest case to reach from the ports is a host write that lands in the middle of a walk. Only a write that arrives while `busy` is high tests the ignore rule, and only a response that is delayed tests the single-outstanding handshake. The bench slows the memory model's response latency so that the walk is still running, then overwrites the head pointer and search key (the new key would match the first node) and issues a second go. It then checks that the miss result and the request count belong to the original walk. The main sweep covers every list length from 0 to 5, every match position plus the miss case, and three field-offset layouts, while the memory model varies its ready and latency pattern from request to request.

// File: rtl/cse_pkg.sv
// Shared constants and types of the linked-list walker.
// Assumes load identifiers fit in one bit (key load, link load).
package cse_pkg;
    // Host register offsets.
    localparam int unsigned REG_KID  = 0;
    localparam int unsigned REG_HEAD = 1;
    localparam int unsigned REG_KEY  = 2;
    localparam int unsigned REG_KOFF = 3;
    localparam int unsigned REG_NOFF = 4;
    localparam int unsigned REG_GO   = 7;

    // Kernel selector value that picks the tail kernel; any other value searches.
    localparam int unsigned KID_TAIL = 1;

    typedef enum logic [0:0] {
        PC_KEY  = 1'b0,
        PC_NEXT = 1'b1
    } load_pc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_KEY,
        ST_PUSH_NEXT,
        ST_ISSUE,
        ST_WAIT,
        ST_EVAL
    } walk_state_e;
endpackage

// File: rtl/cse_regs.sv
// Host register file of the walker: kernel selector, head, key, field offsets, go.
// Assumes: writes are single-cycle strobes; every write is dropped while busy.
module cse_regs
    import cse_pkg::*;
#(
    parameter int AW  = 16,
    parameter int KW  = 4,
    parameter int RAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           busy,
    output logic [KW-1:0]  kid,
    output logic [AW-1:0]  root,
    output logic [AW-1:0]  key,
    output logic [AW-1:0]  key_off,
    output logic [AW-1:0]  next_off,
    output logic           start
);
    logic wr_ok;
    assign wr_ok = cfg_we && !busy;

    // Go pulse: only when idle and bit 0 is set.
    assign start = wr_ok && (cfg_addr == RAW'(REG_GO)) && cfg_wdata[0];

    // Capture configuration writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kid      <= '0;
            root     <= '0;
            key      <= '0;
            key_off  <= '0;
            next_off <= '0;
        end else if (wr_ok) begin
            if (cfg_addr == RAW'(REG_KID))  kid      <= cfg_wdata[KW-1:0];
            if (cfg_addr == RAW'(REG_HEAD)) root     <= cfg_wdata;
            if (cfg_addr == RAW'(REG_KEY))  key      <= cfg_wdata;
            if (cfg_addr == RAW'(REG_KOFF)) key_off  <= cfg_wdata;
            if (cfg_addr == RAW'(REG_NOFF)) next_off <= cfg_wdata;
        end
    end

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(root) && $stable(key) && $stable(kid)
                              && $stable(key_off) && $stable(next_off))); // R9
endmodule

// File: rtl/cse_ready_queue.sv
// Ready queue of pending loads; each entry is {load id, base, offset}.
// Assumes: DEPTH >= 2; flush wins over push and pop in the same cycle.
module cse_ready_queue #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (PW+1)'(DEPTH));
    assign dout    = slots[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    // Entry storage; no reset needed, occupancy guards reads.
    always_ff @(posedge clk) begin
        if (do_push && !flush) slots[wr_ptr] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
endmodule

// File: rtl/cse_result_buf.sv
// Result buffer: one word per load identifier, written on each load response.
// Assumes: NPC identifiers, read port combinational.
module cse_result_buf #(
    parameter int AW  = 16,
    parameter int NPC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NPC)-1:0] wr_pc,
    input  logic [AW-1:0]          wr_data,
    input  logic [$clog2(NPC)-1:0] rd_pc,
    output logic [AW-1:0]          rd_data
);
    localparam int PCW = $clog2(NPC);

    logic [AW-1:0] slot [NPC];

    for (genvar g = 0; g < NPC; g++) begin : g_slot
        // Store the returned word under its load identifier.
        always_ff @(posedge clk) begin
            if (!rst_n)                                slot[g] <= '0;
            else if (wr_en && (wr_pc == PCW'(g)))      slot[g] <= wr_data;
        end
    end

    assign rd_data = slot[rd_pc];
endmodule

// File: rtl/cse_walk_ctrl.sv
// Walk sequencer: queues loads per node, issues one at a time, evaluates the
// returned words and decides between continue, match and end of list.
// Assumes: memory answers each accepted request with exactly one response.
module cse_walk_ctrl
    import cse_pkg::*;
#(
    parameter int AW = 16,
    parameter int KW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] kid,
    input  logic [AW-1:0] root,
    input  logic [AW-1:0] key,
    input  logic [AW-1:0] key_off,
    input  logic [AW-1:0] next_off,
    output logic          q_push,
    output logic [2*AW:0] q_din,
    output logic          q_pop,
    output logic          q_flush,
    input  logic [2*AW:0] q_dout,
    input  logic          q_empty,
    output logic          rb_we,
    output logic [0:0]    rb_pc,
    input  logic [AW-1:0] rb_rd,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic          mem_req_tag,
    input  logic          mem_rsp_valid,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic [AW-1:0] result_ptr
);
    walk_state_e   state;
    logic [AW-1:0] cur;
    load_pc_e      infl;
    logic          tail_mode;
    logic          key_hit;
    load_pc_e      head_pc;
    logic [AW-1:0] head_base, head_off;

    assign tail_mode = (kid == KW'(KID_TAIL));
    assign head_pc   = load_pc_e'(q_dout[2*AW]);
    assign head_base = q_dout[2*AW-1:AW];
    assign head_off  = q_dout[AW-1:0];
    assign key_hit   = !tail_mode && (infl == PC_KEY) && (rb_rd == key);

    // Address generation and request channel.
    assign mem_req_valid = (state == ST_ISSUE) && !q_empty;
    assign mem_req_addr  = head_base + head_off;
    assign mem_req_tag   = head_pc;
    assign q_pop         = mem_req_valid && mem_req_ready;
    assign rb_pc         = infl;
    assign busy          = (state != ST_IDLE);

    // Queue pushes, result capture and flush on match.
    always_comb begin
        q_push  = 1'b0;
        q_din   = {PC_KEY, cur, key_off};
        q_flush = 1'b0;
        rb_we   = 1'b0;
        case (state)
            ST_PUSH_KEY:  q_push = 1'b1;
            ST_PUSH_NEXT: begin
                q_push = 1'b1;
                q_din  = {PC_NEXT, cur, next_off};
            end
            ST_WAIT:      rb_we   = mem_rsp_valid;
            ST_EVAL:      q_flush = key_hit;
            default:      ;
        endcase
    end

    // Walk state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur        <= '0;
            infl       <= PC_KEY;
            done       <= 1'b0;
            found      <= 1'b0;
            result_ptr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    found      <= 1'b0;
                    result_ptr <= '0;
                    if (root == '0) begin
                        done <= 1'b1;
                    end else begin
                        done  <= 1'b0;
                        cur   <= root;
                        state <= tail_mode ? ST_PUSH_NEXT : ST_PUSH_KEY;
                    end
                end
                ST_PUSH_KEY:  state <= ST_PUSH_NEXT;
                ST_PUSH_NEXT: state <= ST_ISSUE;
                ST_ISSUE: if (q_pop) begin
                    infl  <= head_pc;
                    state <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) state <= ST_EVAL;
                ST_EVAL: begin
                    if (infl == PC_KEY) begin
                        if (key_hit) begin
                            done       <= 1'b1;
                            found      <= 1'b1;
                            result_ptr <= cur;
                            state      <= ST_IDLE;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end else if (rb_rd == '0) begin
                        done       <= 1'b1;
                        found      <= tail_mode;
                        result_ptr <= tail_mode ? cur : '0;
                        state      <= ST_IDLE;
                    end else begin
                        cur   <= rb_rd;
                        state <= tail_mode ? ST_PUSH_NEXT : ST_PUSH_KEY;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag))); // R8
    AST_RSP_ONLY_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (state == ST_WAIT)); // R8
    AST_MISS_NULL_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (result_ptr == '0)); // R5
    AST_MATCH_HAS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && found && !tail_mode) |-> (rb_rd == key)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(done) && $stable(found) && $stable(result_ptr))); // R10
endmodule

// File: rtl/chain_seek_engine.sv
// Top of the linked-list walker: host registers, ready queue, result buffer
// and walk sequencer. Assumes one outstanding load on the memory port.
module chain_seek_engine
    import cse_pkg::*;
#(
    parameter int AW     = 16,
    parameter int KW     = 4,
    parameter int RAW    = 3,
    parameter int QDEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [AW-1:0]  cfg_wdata,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    output logic           mem_req_tag,
    input  logic           mem_rsp_valid,
    input  logic [AW-1:0]  mem_rsp_data,
    output logic           busy,
    output logic           done,
    output logic           found,
    output logic [AW-1:0]  result_ptr
);
    localparam int QW = 2 * AW + 1;

    logic [KW-1:0] kid;
    logic [AW-1:0] root, key, key_off, next_off, rb_rd;
    logic          start, q_push, q_pop, q_flush, q_empty, q_full, rb_we;
    logic [QW-1:0] q_din, q_dout;
    logic [0:0]    rb_pc;

    cse_regs #(.AW(AW), .KW(KW), .RAW(RAW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .busy(busy), .kid(kid), .root(root), .key(key),
        .key_off(key_off), .next_off(next_off), .start(start)
    );

    cse_ready_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
        .flush(q_flush), .dout(q_dout), .empty(q_empty), .full(q_full)
    );

    cse_result_buf #(.AW(AW), .NPC(2)) u_rbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(rb_we), .wr_pc(rb_pc),
        .wr_data(mem_rsp_data), .rd_pc(rb_pc), .rd_data(rb_rd)
    );

    cse_walk_ctrl #(.AW(AW), .KW(KW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .kid(kid), .root(root),
        .key(key), .key_off(key_off), .next_off(next_off),
        .q_push(q_push), .q_din(q_din), .q_pop(q_pop), .q_flush(q_flush),
        .q_dout(q_dout), .q_empty(q_empty), .rb_we(rb_we), .rb_pc(rb_pc),
        .rb_rd(rb_rd), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .busy(busy), .done(done), .found(found),
        .result_ptr(result_ptr)
    );

    AST_QUEUE_NEVER_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !q_full); // R3
endmodule

// File: tb/chain_seek_engine_test.sv
module chain_seek_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          mem_req_valid, mem_req_tag;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_data = '0;
    logic          busy, done, found;
    logic [AW-1:0] result_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_seek_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done), .found(found),
        .result_ptr(result_ptr)
    );

    logic [AW-1:0] mem [0:255];
    int            cyc = 0;
    int            hs_cnt = 0;
    logic [AW-1:0] hs_addr = '0;
    logic          hs_tag = 1'b0;
    int            seen = 0;
    int            wait_n = 0;
    logic          pend = 1'b0;
    int            slow = 0;
    int            checks = 0;
    int            fails = 0;

    // Request capture at the edge where the handshake happens.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            hs_cnt  <= hs_cnt + 1;
            hs_addr <= mem_req_addr;
            hs_tag  <= mem_req_tag;
        end
    end

    // Memory model: varying ready pattern and latency, driven off the edge.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (hs_cnt != seen) begin
            seen   = hs_cnt;
            pend   = 1'b1;
            wait_n = (hs_cnt % 3) + slow;
        end
        if (pend) begin
            if (wait_n == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[hs_addr[7:0]];
                pend          = 1'b0;
            end else begin
                wait_n = wait_n - 1;
            end
        end
        mem_req_ready = !pend && ((cyc % 4) != 2);
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a[2:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic int naddr(input int t, input int i);
        return 200 - i * 30 - (t % 3) * 2;
    endfunction

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 3000) chk("R2 walk completes", 32'(done), 32'h1);
    endtask

    // One walk: n nodes, match position m (m == n: miss), layout op, kernel.
    task automatic run(input int t, input int n, input int m, input int op,
                       input bit tail, input bit probe);
        int koff = op;
        int noff = 3 + op;
        logic [AW-1:0] skey;
        int base;
        int kid;
        for (int a = 0; a < 256; a++) mem[a] = 16'hBEEF;
        for (int i = 0; i < n; i++) begin
            mem[naddr(t, i) + koff] = 16'(16'h1000 + i * 7 + t);
            mem[naddr(t, i) + noff] = (i == n - 1) ? 16'h0 : 16'(naddr(t, i + 1));
        end
        skey = (m < n) ? 16'(16'h1000 + m * 7 + t) : 16'hFFFF;
        kid  = tail ? 1 : ((op == 0) ? 0 : ((op == 1) ? 2 : 15));
        wr(0, 16'(kid));
        wr(1, (n > 0) ? 16'(naddr(t, 0)) : 16'h0);
        wr(2, skey);
        wr(3, 16'(koff));
        wr(4, 16'(noff));
        base = hs_cnt;
        wr(7, 16'h1);
        if (n > 0) begin
            chk("R2 busy after go", 32'(busy), 32'h1);
            chk("R2 done cleared by go", 32'(done), 32'h0);
        end
        if (probe) begin
            // R9: overwrite head and key (key of node 0) and go again while busy.
            wr(1, 16'h0);
            wr(2, 16'(16'h1000 + t));
            wr(7, 16'h1);
        end
        wait_done();
        if (tail) begin
            chk("R6 found", 32'(found), (n > 0) ? 32'h1 : 32'h0);
            chk("R6 ptr", 32'(result_ptr), (n > 0) ? 32'(naddr(t, n - 1)) : 32'h0);
            chk("R6 request count", 32'(hs_cnt - base), 32'(n));
            if (n > 0) chk("R6 last load is link", 32'(hs_tag), 32'h1);
        end else if (n == 0) begin
            chk("R7 found", 32'(found), 32'h0);
            chk("R7 ptr", 32'(result_ptr), 32'h0);
            chk("R7 no request", 32'(hs_cnt - base), 32'h0);
        end else if (m < n) begin
            chk(probe ? "R9 found" : "R4 found", 32'(found), 32'h1);
            chk("R4 ptr", 32'(result_ptr), 32'(naddr(t, m)));
            chk("R4 request count", 32'(hs_cnt - base), 32'(2 * m + 1));
            chk("R3 last address key field", 32'(hs_addr), 32'(naddr(t, m) + koff));
            chk("R3 last tag key", 32'(hs_tag), 32'h0);
        end else begin
            chk(probe ? "R9 found" : "R5 found", 32'(found), 32'h0);
            chk(probe ? "R9 ptr" : "R5 ptr", 32'(result_ptr), 32'h0);
            chk(probe ? "R9 request count" : "R5 request count", 32'(hs_cnt - base), 32'(2 * n));
            chk("R3 last address link field", 32'(hs_addr), 32'(naddr(t, n - 1) + noff));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int t = 0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 32'h0);
        chk("R1 req_valid in reset", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'h0);
        chk("R1 found after reset", 32'(found), 32'h0);
        chk("R1 ptr after reset", 32'(result_ptr), 32'h0);
        chk("R1 busy after reset", 32'(busy), 32'h0);

        // Search kernel sweep: lengths, match positions, layouts.
        for (int n = 0; n <= 5; n++)
            for (int m = 0; m <= n; m++)
                for (int op = 0; op < 3; op++) begin
                    run(t, n, m, op, 1'b0, 1'b0);
                    t++;
                end

        // Tail kernel sweep.
        for (int n = 0; n <= 5; n++) begin
            run(t, n, 0, n % 3, 1'b1, 1'b0);
            t++;
        end

        // Writes during a slow walk are ignored; results then hold.
        slow = 5;
        run(t, 4, 4, 1, 1'b0, 1'b1);
        slow = 0;
        repeat (12) @(negedge clk);
        chk("R10 done holds", 32'(done), 32'h1);
        chk("R10 found holds", 32'(found), 32'h0);
        chk("R10 ptr holds", 32'(result_ptr), 32'h0);
        chk("R8 no request while idle", 32'(mem_req_valid), 32'h0);

        // Result of a match holds until the next go.
        run(t + 1, 3, 2, 2, 1'b0, 1'b0);
        repeat (12) @(negedge clk);
        chk("R10 match ptr holds", 32'(result_ptr), 32'(naddr(t + 1, 2)));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule